// File: doc/BRIEF.md
# External Bus Strobe Generator

This block produces the two timing strobes of a multiplexed external memory bus and picks the source for the upper address byte. The first strobe is the address latch pulse, active high. The second is the code-read strobe, active low. A machine cycle is twelve oscillator periods. The core supplies the position within that cycle as a phase number from 0 to 11. Together with that number it supplies flags that describe the current machine cycle: whether code is being fetched from external memory, whether the cycle moves data through a 16-bit pointer or an 8-bit pointer, and whether a data-move or code-table-read instruction is in progress.

In normal operation the address latch pulse runs at one sixth of the oscillator rate. The code-read strobe pulses twice per machine cycle while code executes externally. In a machine cycle that transfers external data, the first latch pulse and both code-read pulses are left out. A control bit can switch the latch pulse off to reduce noise. While it is switched off, the latch output rests at a weak-high level, modelled as a constant 1. It still pulses during data-move and code-table-read instructions, and the bit is ignored whenever code runs from external memory. All outputs are registered, so each one follows the inputs of the previous clock.

Top module: `ext_bus_strobe`

## Requirements
- R1: While reset is held, `ale` is 0, `psen_n` is 1, `hi_sel` is 0 and `hi_byte` is 0.
- R2: When no data cycle is flagged and the disable bit is clear, `ale` is 1 for exactly one clock after each clock with `phase` equal to 1 or 7, and 0 after every other clock.
- R3: With `ext_code` at 1 and no data cycle flagged, `psen_n` is 0 after each clock with `phase` in 3..5 or 9..11, and 1 otherwise. `psen_n` is always 1 when `ext_code` is 0. `ale` at 1 and `psen_n` at 0 never occur together.
- R4: A data cycle is flagged when `xdata_wide` or `xdata_narrow` is 1. During a data cycle, the `ale` pulse that phase 1 would cause is dropped. The pulse that phase 7 causes is still produced.
- R5: During a data cycle, `psen_n` stays 1 for the whole machine cycle, even with `ext_code` at 1.
- R6: When `ale_off` is 1, `ext_code` is 0 and `insn_movx_movc` is 0, `ale` is 1 after every clock.
- R7: When `ale_off` and `insn_movx_movc` are both 1, `ale` follows R2 and R4 as if `ale_off` were 0.
- R8: When `ext_code` is 1, `ale_off` has no effect on `ale`.
- R9: `hi_sel` is 1 and `hi_byte` equals `addr_hi` when `xdata_wide` is 1. The same holds when `ext_code` is 1 and `xdata_narrow` is 0. Otherwise `hi_sel` is 0 and `hi_byte` equals `port_latch` unchanged. `xdata_wide` takes priority over `xdata_narrow`.
- R10: For `phase` values 12 to 15, no `ale` pulse and no `psen_n` assertion is produced. The constant level of R6 still applies.
- R11: Every output reflects the inputs sampled at the preceding rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| phase | input | 4 | Oscillator period within the machine cycle, 0..11 |
| ext_code | input | 1 | Code is being fetched from external memory |
| xdata_wide | input | 1 | This machine cycle transfers external data through a 16-bit pointer |
| xdata_narrow | input | 1 | This machine cycle transfers external data through an 8-bit pointer |
| insn_movx_movc | input | 1 | A data-move or code-table-read instruction is in progress |
| ale_off | input | 1 | Control bit that switches the latch pulse off |
| addr_hi | input | 8 | Upper byte of the current address |
| port_latch | input | 8 | Contents of the upper port's output latch |
| ale | output | 1 | Address latch pulse, active high |
| psen_n | output | 1 | Code-read strobe, active low |
| hi_sel | output | 1 | 1 when the upper byte carries the address, 0 when it carries the port latch |
| hi_byte | output | 8 | Byte driven on the upper address lines |

## Verification
The hardest cases to reach arise where the pulse-skip rule meets the disable bit. One case is a data cycle with the latch switched off but an instruction in progress, where the latch still pulses but must omit its phase-1 pulse. Another is a data cycle in which external code execution overrides the disable bit. The stimulus builds these from directed machine cycles that hold one flag combination for all twelve phases. It then runs a long stretch in which each machine cycle draws a fresh random combination of every flag, with data cycles weighted heavily enough that all these intersections occur many times. A behavioural model compares all four outputs on every clock.

// File: rtl/ebs_pkg.sv
package ebs_pkg;

  typedef struct packed {
    logic ale;
    logic psen_n;
  } strobe_t;

  localparam strobe_t STROBE_IDLE = '{ale: 1'b0, psen_n: 1'b1};

  typedef enum logic {
    SRC_PORT_LATCH = 1'b0,
    SRC_ADDRESS    = 1'b1
  } hi_src_e;

endpackage

// File: rtl/ebs_phase_decode.sv
module ebs_phase_decode #(
  parameter int PHASE_W   = 4,
  parameter int CYCLE_LEN = 12,
  parameter int ALE_OFS   = 1,
  parameter int PSEN_OFS  = 3,
  parameter int PSEN_LEN  = 3
) (
  input  logic [PHASE_W-1:0] phase,
  output logic               ale_slot,
  output logic               ale_first_slot,
  output logic               psen_slot
);

  localparam int HALF_LEN = CYCLE_LEN / 2;
  localparam int N_HALVES = 2;

  logic [N_HALVES-1:0] ale_hit;
  logic [N_HALVES-1:0] psen_hit;

  // One latch slot and one code-read window in each half of the machine cycle
  for (genvar g = 0; g < N_HALVES; g++) begin : g_half
    localparam int ALE_POS = ALE_OFS + g * HALF_LEN;
    localparam int PS_LO   = PSEN_OFS + g * HALF_LEN;
    localparam int PS_HI   = PS_LO + PSEN_LEN;

    assign ale_hit[g]  = (phase == PHASE_W'(ALE_POS));
    assign psen_hit[g] = (phase >= PHASE_W'(PS_LO)) && (phase < PHASE_W'(PS_HI));
  end

  assign ale_slot       = |ale_hit;
  assign ale_first_slot = ale_hit[0];
  assign psen_slot      = |psen_hit;

endmodule

// File: rtl/ebs_strobe_gen.sv
module ebs_strobe_gen
  import ebs_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    ale_slot,
  input  logic    ale_first_slot,
  input  logic    psen_slot,
  input  logic    ext_code,
  input  logic    data_cycle,
  input  logic    insn_active,
  input  logic    ale_off,
  output strobe_t strb_q
);

  strobe_t strb_d;
  logic    gate_forced;
  logic    skip_first;
  logic    strb_en;

  // Next-state logic
  always_comb begin
    gate_forced   = ale_off && !ext_code && !insn_active;
    skip_first    = data_cycle && ale_first_slot;
    strb_d.ale    = gate_forced ? 1'b1 : (ale_slot && !skip_first);
    strb_d.psen_n = !(psen_slot && ext_code && !data_cycle);
    strb_en       = (strb_d != strb_q);
  end

  // Register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strb_q <= STROBE_IDLE;
    end else if (strb_en) begin
      strb_q <= strb_d;
    end
  end

  // R3: latch pulse and code-read strobe never overlap
  a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(strb_q.ale && !strb_q.psen_n));

  // R4: the first latch slot of a data cycle yields no pulse unless forced high
  a_r4_skip_first: assert property (@(posedge clk) disable iff (!rst_n)
    (data_cycle && ale_first_slot && !ale_off) |=> !strb_q.ale);

  // R5: code-read strobe stays inactive through a data cycle
  a_r5_psen_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    data_cycle |=> strb_q.psen_n);

  // R6: disabled latch output rests at the weak-high level
  a_r6_weak_high: assert property (@(posedge clk) disable iff (!rst_n)
    (ale_off && !ext_code && !insn_active) |=> strb_q.ale);

  // R3: internal execution never asserts the code-read strobe
  a_r3_internal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_code |=> strb_q.psen_n);

endmodule

// File: rtl/ebs_addr_mux.sv
module ebs_addr_mux
  import ebs_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_code,
  input  logic              xdata_wide,
  input  logic              xdata_narrow,
  input  logic [BYTE_W-1:0] addr_hi,
  input  logic [BYTE_W-1:0] port_latch,
  output hi_src_e           src_q,
  output logic [BYTE_W-1:0] byte_q
);

  hi_src_e           src_d;
  logic [BYTE_W-1:0] byte_d;
  logic              upd_en;

  // Next-state logic: wide pointer first, then narrow pointer, then code fetch
  always_comb begin
    if (xdata_wide) begin
      src_d = SRC_ADDRESS;
    end else if (xdata_narrow) begin
      src_d = SRC_PORT_LATCH;
    end else if (ext_code) begin
      src_d = SRC_ADDRESS;
    end else begin
      src_d = SRC_PORT_LATCH;
    end
    byte_d = (src_d == SRC_ADDRESS) ? addr_hi : port_latch;
    upd_en = (src_d != src_q) || (byte_d != byte_q);
  end

  // Register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= SRC_PORT_LATCH;
      byte_q <= '0;
    end else if (upd_en) begin
      src_q  <= src_d;
      byte_q <= byte_d;
    end
  end

  // R9: narrow-pointer access drives the port latch untouched
  a_r9_narrow_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (xdata_narrow && !xdata_wide) |=>
      (src_q == SRC_PORT_LATCH) && (byte_q == $past(port_latch)));

  // R9: wide-pointer access drives the address byte
  a_r9_wide_addr: assert property (@(posedge clk) disable iff (!rst_n)
    xdata_wide |=> (src_q == SRC_ADDRESS) && (byte_q == $past(addr_hi)));

endmodule

// File: rtl/ext_bus_strobe.sv
module ext_bus_strobe
  import ebs_pkg::*;
#(
  parameter int PHASE_W   = 4,
  parameter int CYCLE_LEN = 12,
  parameter int ALE_OFS   = 1,
  parameter int PSEN_OFS  = 3,
  parameter int PSEN_LEN  = 3,
  parameter int BYTE_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PHASE_W-1:0] phase,
  input  logic              ext_code,
  input  logic              xdata_wide,
  input  logic              xdata_narrow,
  input  logic              insn_movx_movc,
  input  logic              ale_off,
  input  logic [BYTE_W-1:0] addr_hi,
  input  logic [BYTE_W-1:0] port_latch,
  output logic              ale,
  output logic              psen_n,
  output logic              hi_sel,
  output logic [BYTE_W-1:0] hi_byte
);

  localparam int SYNC_LEN = 2;

  logic [SYNC_LEN-1:0] rst_sync_q;
  logic                rst_int_n;
  logic                ale_slot;
  logic                ale_first_slot;
  logic                psen_slot;
  logic                data_cycle;
  strobe_t             strb_q;
  hi_src_e             src_q;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_LEN-2:0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[SYNC_LEN-1];

  assign data_cycle = xdata_wide || xdata_narrow;

  ebs_phase_decode #(
    .PHASE_W  (PHASE_W),
    .CYCLE_LEN(CYCLE_LEN),
    .ALE_OFS  (ALE_OFS),
    .PSEN_OFS (PSEN_OFS),
    .PSEN_LEN (PSEN_LEN)
  ) u_decode (
    .phase         (phase),
    .ale_slot      (ale_slot),
    .ale_first_slot(ale_first_slot),
    .psen_slot     (psen_slot)
  );

  ebs_strobe_gen u_strobe (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .ale_slot      (ale_slot),
    .ale_first_slot(ale_first_slot),
    .psen_slot     (psen_slot),
    .ext_code      (ext_code),
    .data_cycle    (data_cycle),
    .insn_active   (insn_movx_movc),
    .ale_off       (ale_off),
    .strb_q        (strb_q)
  );

  ebs_addr_mux #(
    .BYTE_W(BYTE_W)
  ) u_addr (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .ext_code    (ext_code),
    .xdata_wide  (xdata_wide),
    .xdata_narrow(xdata_narrow),
    .addr_hi     (addr_hi),
    .port_latch  (port_latch),
    .src_q       (src_q),
    .byte_q      (hi_byte)
  );

  assign ale    = strb_q.ale;
  assign psen_n = strb_q.psen_n;
  assign hi_sel = src_q;

endmodule

// File: tb/ext_bus_strobe_tb.sv
module ext_bus_strobe_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] phase;
  logic       ext_code, xdata_wide, xdata_narrow, insn_movx_movc, ale_off;
  logic [7:0] addr_hi, port_latch;
  logic       ale, psen_n, hi_sel;
  logic [7:0] hi_byte;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // Expectations for the next negedge sample, with requirement tags
  logic  e_ale, e_psen_n, e_sel;
  logic [7:0] e_byte;
  string t_ale, t_psen, t_sel;

  always #2.5 clk = ~clk;

  ext_bus_strobe u_dut (
    .clk(clk), .rst_n(rst_n), .phase(phase), .ext_code(ext_code),
    .xdata_wide(xdata_wide), .xdata_narrow(xdata_narrow),
    .insn_movx_movc(insn_movx_movc), .ale_off(ale_off),
    .addr_hi(addr_hi), .port_latch(port_latch),
    .ale(ale), .psen_n(psen_n), .hi_sel(hi_sel), .hi_byte(hi_byte)
  );

  task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h (phase in=%0d t=%0t)", tag, what, act, exp, phase, $time);
    end
  endtask

  // Behavioural reference: expectation from the inputs now applied
  task automatic model();
    int  ph  = int'(phase);
    bit  xd  = xdata_wide || xdata_narrow;
    bit  forced = ale_off && !ext_code && !insn_movx_movc;
    bit  pulse  = (ph == 1) || (ph == 7);
    bit  win    = (ph < 12) && ((ph % 6) >= 3);
    if (xd && ph == 1) pulse = 0;
    e_ale = forced ? 1'b1 : pulse;
    if (forced)                          t_ale = "R6";
    else if (xd && ph == 1)              t_ale = "R4";
    else if (ale_off && insn_movx_movc)  t_ale = "R7";
    else if (ale_off && ext_code)        t_ale = "R8";
    else if (ph >= 12)                   t_ale = "R10";
    else                                 t_ale = "R2";
    e_psen_n = !(ext_code && !xd && win);
    if (xd && ext_code && win) t_psen = "R5";
    else if (ph >= 12)         t_psen = "R10";
    else                       t_psen = "R3";
    if (xdata_wide || (ext_code && !xdata_narrow)) begin
      e_sel = 1'b1; e_byte = addr_hi;
    end else begin
      e_sel = 1'b0; e_byte = port_latch;
    end
    t_sel = "R9";
  endtask

  // R11: outputs sampled at this negedge follow the inputs applied one clock earlier
  task automatic compare();
    chk(t_ale,  "ale",     {7'd0, ale},    {7'd0, e_ale});
    chk(t_psen, "psen_n",  {7'd0, psen_n}, {7'd0, e_psen_n});
    chk(t_sel,  "hi_sel",  {7'd0, hi_sel}, {7'd0, e_sel});
    chk(t_sel,  "hi_byte", hi_byte,        e_byte);
    if (ale && !psen_n) chk("R3", "overlap", 8'd1, 8'd0);
  endtask

  task automatic step(input int ph, input bit ext, input bit w, input bit n,
                      input bit mv, input bit off, input logic [7:0] ah, input logic [7:0] pl);
    @(negedge clk);
    compare();
    phase = 4'(ph); ext_code = ext; xdata_wide = w; xdata_narrow = n;
    insn_movx_movc = mv; ale_off = off; addr_hi = ah; port_latch = pl;
    model();
  endtask

  task automatic mcycle(input bit ext, input bit w, input bit n, input bit mv,
                        input bit off, input logic [7:0] ah, input logic [7:0] pl);
    for (int p = 0; p < 12; p++) step(p, ext, w, n, mv, off, ah, pl);
  endtask

  initial begin
    rst_n = 1'b0;
    phase = '0; ext_code = 0; xdata_wide = 0; xdata_narrow = 0;
    insn_movx_movc = 0; ale_off = 0; addr_hi = 8'h00; port_latch = 8'h00;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "ale",     {7'd0, ale},    8'd0);
    chk("R1", "psen_n",  {7'd0, psen_n}, 8'd1);
    chk("R1", "hi_sel",  {7'd0, hi_sel}, 8'd0);
    chk("R1", "hi_byte", hi_byte,        8'd0);
    rst_n = 1'b1;
    model();
    repeat (4) step(0, 0, 0, 0, 0, 0, 8'h00, 8'h00);

    // R2: internal execution, free-running latch pulse
    repeat (2) mcycle(0, 0, 0, 0, 0, 8'h12, 8'hA5);
    // R3: external code fetch, two code-read pulses per machine cycle
    repeat (2) mcycle(1, 0, 0, 0, 0, 8'h3C, 8'h5A);
    // R4 R5 R9: wide-pointer data cycle between code fetches
    mcycle(1, 1, 0, 1, 0, 8'hC3, 8'h77);
    mcycle(1, 0, 0, 0, 0, 8'h40, 8'h77);
    // R4 R5 R9: narrow-pointer data cycle, port latch passes through
    mcycle(1, 0, 1, 1, 0, 8'hEE, 8'h96);
    mcycle(0, 0, 1, 1, 0, 8'hEE, 8'h69);
    // R9: both pointer flags, wide wins
    mcycle(0, 1, 1, 1, 0, 8'hB4, 8'h4B);
    // R6: latch switched off, internal, no instruction
    repeat (2) mcycle(0, 0, 0, 0, 1, 8'h01, 8'h02);
    // R7: latch switched off but instruction active, with and without data cycle
    mcycle(0, 0, 0, 1, 1, 8'h03, 8'h04);
    mcycle(0, 0, 1, 1, 1, 8'h05, 8'h06);
    // R8: external code overrides the disable bit, also in a data cycle
    mcycle(1, 0, 0, 0, 1, 8'h07, 8'h08);
    mcycle(1, 1, 0, 0, 1, 8'h09, 8'h0A);
    // R10: out-of-range phases
    for (int p = 12; p < 16; p++) step(p, 1, 0, 0, 0, 0, 8'h11, 8'h22);
    for (int p = 12; p < 16; p++) step(p, 0, 0, 0, 0, 1, 8'h11, 8'h22);
    for (int p = 12; p < 16; p++) step(p, 0, 0, 0, 1, 1, 8'h11, 8'h22);

    // Randomised machine cycles
    for (int k = 0; k < 600; k++) begin
      bit ext = bit'($urandom_range(0, 1));
      bit w   = ($urandom_range(0, 3) == 0);
      bit n   = ($urandom_range(0, 3) == 0);
      bit mv  = bit'($urandom_range(0, 1));
      bit off = bit'($urandom_range(0, 1));
      logic [7:0] ah = 8'($urandom_range(0, 255));
      logic [7:0] pl = 8'($urandom_range(0, 255));
      mcycle(ext, w, n, mv, off, ah, pl);
    end
    @(negedge clk);
    compare();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule